// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side and decides when a flash program or erase operation has finished. A pulse on `start` makes it issue pairs of status reads over a plain request/acknowledge read port. It compares the chosen toggle bit across the two reads of each pair. It also looks at the exceeded-time flag in the second read of each pair. From these it settles on pass or fail. On a fail it asks for the reset command to be written, so that the device goes back to array-read mode.

The device bus timing and the command writes belong to the surrounding logic. That logic turns `rd_req` into device reads and returns each status byte with a one-cycle `rd_ack`. Polling can be abandoned at any time with `abort`. The next `start` then begins again from the first read pair.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, `rd_req`, `done`, `pass`, `fail` and `reset_cmd_req` are all low.
- R2: A `start` seen while idle begins polling, and polling always begins with a fresh pair of reads. The monitored toggle bit is status bit 6 when `sel_dq2`=0 and status bit 2 when `sel_dq2`=1. The unselected bit has no effect on the result.
- R3: If the monitored bit has the same value in both reads of a pair, the operation ends with `pass`=1.
- R4: If the monitored bit differs within a pair and status bit 5 of the second read is 0, another read pair follows.
- R5: If the monitored bit differs and status bit 5 of the second read is 1, exactly one recheck pair follows. If that recheck pair is steady, the operation ends with `pass`=1.
- R6: If the recheck pair still differs, the operation ends with `fail`=1 and `reset_cmd_req`=1.
- R7: If MAX_PAIRS is non-zero and MAX_PAIRS consecutive pairs all differ, the operation ends with `fail`=1 and `reset_cmd_req`=1 after exactly 2*MAX_PAIRS reads.
- R8: `done` is a one-cycle pulse. It rises in the cycle after the acknowledge of the final read. `pass` and `fail` are valid with it, exactly one of them is set, and they hold until the next accepted `start`. `reset_cmd_req` pulses only together with `done` and `fail`.
- R9: A `start` pulse during polling is ignored. The read sequence and the result stay the same as without it.
- R10: `abort` returns the block to idle in the next cycle. It drops `rd_req` and produces no `done`.
- R11: A read is held requested (`rd_req`=1) until a cycle with `rd_ack`=1, and the status byte is taken in that cycle. The two reads of a pair are requested back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling (accepted only when idle) |
| abort | input | 1 | Abandon polling and return to idle |
| sel_dq2 | input | 1 | 0: monitor status bit 6, 1: monitor status bit 2 |
| rd_req | output | 1 | Status read requested |
| rd_ack | input | 1 | Status byte valid on rd_data this cycle |
| rd_data | input | 8 | Status byte read from the device |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation completed successfully |
| fail | output | 1 | Operation failed or timed out |
| reset_cmd_req | output | 1 | Request to write the reset command |

## Verification
A wrong internal state in this block shows up as a wrong number of acknowledged reads before `done`, or as the wrong verdict on `pass`, `fail` and `reset_cmd_req`. Examples are a lost recheck flag, a stale first-read bit or a miscounted pair. The bench counts every read handshake and compares the count and the verdict with a model of the polling rules. Any such fault is therefore visible no later than the cycle after the acknowledge of the final read. A stuck state after `abort` shows up one cycle later as `rd_req` still high.

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl #(
  parameter int MAX_PAIRS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic       sel_dq2,
  output logic       rd_req,
  input  logic       rd_ack,
  input  logic [7:0] rd_data,
  output logic       done,
  output logic       pass,
  output logic       fail,
  output logic       reset_cmd_req
);
  localparam int CW = $clog2(MAX_PAIRS + 2);

  typedef enum logic [1:0] {IDLE, RD_A, RD_B} st_t;
  st_t st;

  logic          first_bit;
  logic          rechk;
  logic [CW-1:0] pairs;

  wire tbit    = sel_dq2 ? rd_data[2] : rd_data[6];
  wire toggled = tbit ^ first_bit;
  wire limit   = (MAX_PAIRS != 0) && (int'(pairs) + 1 == MAX_PAIRS);

  assign rd_req = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= IDLE;
      first_bit     <= 1'b0;
      rechk         <= 1'b0;
      pairs         <= '0;
      done          <= 1'b0;
      pass          <= 1'b0;
      fail          <= 1'b0;
      reset_cmd_req <= 1'b0;
    end else begin
      done          <= 1'b0;
      reset_cmd_req <= 1'b0;
      if (abort) begin
        st <= IDLE;
      end else begin
        case (st)
          IDLE: if (start) begin
            st    <= RD_A;
            pass  <= 1'b0;
            fail  <= 1'b0;
            pairs <= '0;
            rechk <= 1'b0;
          end
          RD_A: if (rd_ack) begin
            first_bit <= tbit;
            st        <= RD_B;
          end
          RD_B: if (rd_ack) begin
            if (!toggled) begin
              st   <= IDLE;
              done <= 1'b1;
              pass <= 1'b1;
            end else if (rechk || limit) begin
              st            <= IDLE;
              done          <= 1'b1;
              fail          <= 1'b1;
              reset_cmd_req <= 1'b1;
            end else begin
              pairs <= pairs + 1'b1;
              rechk <= rd_data[5];
              st    <= RD_A;
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

module toggle_poll_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic abort,
  input logic rd_req,
  input logic done,
  input logic pass,
  input logic fail,
  input logic reset_cmd_req
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (pass ^ fail));
  // R6
  reset_req_chk: assert property (@(posedge clk) disable iff (!rst_n) reset_cmd_req |-> (done && fail));
  // R8
  idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !rd_req);
  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) abort |=> (!rd_req && !done));
  // R8
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (!done && rd_req) |-> (!pass && !fail));
endmodule

bind toggle_poll_ctrl toggle_poll_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort), .rd_req(rd_req),
  .done(done), .pass(pass), .fail(fail), .reset_cmd_req(reset_cmd_req)
);

// File: tb/toggle_poll_ctrl_test.sv
module toggle_poll_ctrl_test;
  localparam int MAXP = 6;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0, sel_dq2 = 1'b0;
  logic rd_ack = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic rd_req, done, pass, fail, reset_cmd_req;

  int checks = 0, errors = 0;
  bit tb_t[64];
  bit tb_d5[64];

  toggle_poll_ctrl #(.MAX_PAIRS(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .sel_dq2(sel_dq2),
    .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data), .done(done),
    .pass(pass), .fail(fail), .reset_cmd_req(reset_cmd_req)
  );

  always #4ns clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void predict(output int reads, output bit ok);
    int i = 0, pairs = 0;
    bit re = 0;
    reads = 0; ok = 0;
    while (i < 62) begin
      pairs++;
      reads = i + 2;
      if (tb_t[i] == tb_t[i+1]) begin ok = 1; return; end
      if (re || pairs == MAXP) begin ok = 0; return; end
      re = tb_d5[i+1];
      i += 2;
    end
  endfunction

  function automatic logic [7:0] mk(input int i, input bit sel);
    logic [7:0] b;
    b = 8'($urandom);
    b[5] = tb_d5[i];
    if (sel) begin b[2] = tb_t[i]; b[6] = i[0]; end
    else     begin b[6] = tb_t[i]; b[2] = i[0]; end
    return b;
  endfunction

  function automatic void fill_pairs(input int tog_pairs, input int d5_pair, input bit end_tog);
    for (int p = 0; p < 32; p++) begin
      bit a = 1'($urandom);
      bit tg = (p < tog_pairs) || end_tog;
      tb_t[2*p] = a;
      tb_t[2*p+1] = a ^ tg;
      tb_d5[2*p] = 1'($urandom);
      tb_d5[2*p+1] = (p == d5_pair);
    end
  endfunction

  task automatic run_op(input bit sel, input int abort_at, input bit inj, input string tag);
    int idx = 0, dly, cyc = 0, er;
    bit fin = 0, injd = 0, ep;
    predict(er, ep);
    sel_dq2 = sel;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    dly = $urandom % 3;
    while (!fin && cyc < 500) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (done) begin
        rd_ack = 1'b0;
        chk(pass == ep, {"R3/R5 pass ", tag}, pass, ep);
        chk(fail == !ep, {"R6/R7 fail ", tag}, fail, !ep);
        chk(reset_cmd_req == !ep, {"R6 reset_cmd_req ", tag}, reset_cmd_req, !ep);
        chk(idx == er, {"R4/R11 read count ", tag}, idx, er);
        @(negedge clk);
        chk(!done && pass == ep, {"R8 pulse/hold ", tag}, {done, pass}, {1'b0, ep});
        fin = 1;
      end else if (rd_ack) begin
        rd_ack = 1'b0;
      end else if (abort_at > 0 && idx == abort_at) begin
        abort = 1'b1;
        @(negedge clk) abort = 1'b0;
        chk(!rd_req && !done, {"R10 abort ", tag}, {rd_req, done}, 0);
        repeat (3) @(negedge clk) chk(!done && !rd_req, {"R10 no done ", tag}, done, 0);
        fin = 1;
      end else if (rd_req) begin
        if (dly == 0) begin
          rd_ack = 1'b1;
          rd_data = mk(idx, sel);
          idx++;
          dly = $urandom % 3;
        end else dly--;
      end
      if (inj && idx == 1 && !injd) begin start = 1'b1; injd = 1; end
    end
    if (!fin) chk(0, {"R8 no done ", tag}, 0, 1);
  endtask

  initial begin
    int wd = 0;
    while (wd < 200000) begin @(posedge clk); wd++; end
    chk(0, "watchdog", wd, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(1234));
    #20ns;
    chk(!rd_req && !done && !pass && !fail && !reset_cmd_req, "R1 reset state",
        {rd_req, done, pass, fail, reset_cmd_req}, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_req && !done, "R1 idle after reset", {rd_req, done}, 0);

    fill_pairs(0, -1, 0); run_op(0, 0, 0, "R2 steady bit6");
    fill_pairs(0, -1, 0); run_op(1, 0, 0, "R2 steady bit2");
    fill_pairs(2, -1, 0); run_op(0, 0, 0, "R4 two toggling pairs");
    fill_pairs(1, 0, 0);  run_op(1, 0, 0, "R5 recheck steady");
    fill_pairs(2, 0, 0);  run_op(0, 0, 0, "R6 recheck toggling");
    fill_pairs(0, -1, 1); run_op(1, 0, 0, "R7 poll limit");
    fill_pairs(2, -1, 0); run_op(0, 0, 1, "R9 start ignored");
    fill_pairs(0, -1, 1); run_op(0, 3, 0, "R10 abort mid poll");
    fill_pairs(0, -1, 0); run_op(0, 0, 0, "R10 restart after abort");

    for (int k = 0; k < 40; k++) begin
      for (int i = 0; i < 64; i++) begin
        tb_t[i] = 1'($urandom);
        tb_d5[i] = ($urandom % 5 == 0);
      end
      run_op(1'($urandom), 0, ($urandom % 4 == 0), "R11 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule